// File: doc/BRIEF.md
# Streaming Sum and Signed Extremes Tracker

This block watches a stream of two's-complement words, one per clock, and keeps three registered results: the wrapping sum of every word taken since the last clear, the greatest word taken, and the least word taken. All three results come straight from flops, so nothing combinational runs from the data input to any output.

A clear request on `clear_i` is captured in a flop first. For the one cycle in which that flop is high, gates on the three feedback paths replace the held results with fixed start values. The sum and the maximum start at zero. The minimum starts at the largest positive code. The maximum is therefore never below zero, and the minimum is never above the largest positive code. An edge samples the data word only when the registered clear is low at that edge.

Top module: `stream_stats`

## Requirements
- R1: While `rst_ni` is low, `acc_o` and `max_o` are 0 and `min_o` is the largest positive code (0x7FFF at the default width).
- R2: `clear_i` is registered before it acts. The edge that captures `clear_i` high still performs a normal sample. The start values appear only after the following edge.
- R3: At an edge where the registered clear is high, `acc_o` and `max_o` load 0 and `min_o` loads the largest positive code (MSB 0, all other bits 1). The data word present at that edge has no effect.
- R4: At each sampling edge, `acc_o` becomes the low DATA_W bits of the previous `acc_o` plus `data_i`, wrapping on overflow.
- R5: At each sampling edge, `max_o` becomes the signed greater of the previous `max_o` and `data_i`. Because the start value is 0, a run of only negative words leaves `max_o` at 0.
- R6: At each sampling edge, `min_o` becomes the signed lesser of the previous `min_o` and `data_i`.
- R7: The first edge that samples after a clear makes `acc_o` equal to that word. The same edge makes `min_o` equal to it whenever the word is at most the largest positive code.
- R8: The outputs change only at a rising clock edge. A change on `data_i` between edges leaves all three outputs unchanged.
- R9: If `clear_i` is held high for several cycles, the outputs stay at the start values until the first edge at which the registered clear is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear request, registered before use |
| data_i | input | DATA_W | Signed input word |
| acc_o | output | DATA_W | Wrapping sum since the last clear |
| max_o | output | DATA_W | Signed maximum since the last clear (floor 0) |
| min_o | output | DATA_W | Signed minimum since the last clear |

## Verification
The bench builds the block with its default DATA_W of 16. At that width, two 0x7000 words push the sum past the top of the code space, which exercises wrap-around. Single words of 0x8000 and 0x7FFF reach the signed extremes, which exercises the comparators at their edges and the gap between the two start values. At 16 bits, every stimulus word is also an exact value that can be checked against a model running in the bench.

// File: rtl/stream_stats_pkg.sv
package stream_stats_pkg;
  // which start value a feedback gate forces while the registered clear is high
  typedef enum logic [1:0] {
    FB_SUM = 2'd0,
    FB_MAX = 2'd1,
    FB_MIN = 2'd2
  } fb_kind_e;
endpackage

// File: rtl/fb_gate.sv
module fb_gate
  import stream_stats_pkg::*;
#(
  parameter int       W    = 16,
  parameter fb_kind_e KIND = FB_SUM
) (
  input  logic         clr_i,
  input  logic [W-1:0] fb_i,
  output logic [W-1:0] fb_o
);
  if (KIND == FB_MIN) begin : g_min
    // sign bit via AND, magnitude bits via OR -> largest positive code
    assign fb_o = {fb_i[W-1] & ~clr_i, fb_i[W-2:0] | {(W-1){clr_i}}};
  end else begin : g_zero
    assign fb_o = fb_i & {W{~clr_i}};
  end
endmodule

// File: rtl/sum_track.sv
module sum_track
  import stream_stats_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] fb, din, sum;

  fb_gate #(.W(W), .KIND(FB_SUM)) u_fb (.clr_i(clr_i), .fb_i(q_o), .fb_o(fb));
  fb_gate #(.W(W), .KIND(FB_SUM)) u_din (.clr_i(clr_i), .fb_i(data_i), .fb_o(din));

  assign sum = fb + din;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= sum;
  end
endmodule

// File: rtl/extreme_track.sv
module extreme_track
  import stream_stats_pkg::*;
#(
  parameter int       W    = 16,
  parameter fb_kind_e KIND = FB_MAX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] START = (KIND == FB_MIN) ? {1'b0, {(W-1){1'b1}}} : '0;

  logic [W-1:0] fb;
  logic         beats;

  fb_gate #(.W(W), .KIND(KIND)) u_fb (.clr_i(clr_i), .fb_i(q_o), .fb_o(fb));

  if (KIND == FB_MIN) begin : g_lt
    assign beats = ~clr_i & ($signed(data_i) < $signed(fb));
  end else begin : g_gt
    assign beats = ~clr_i & ($signed(data_i) > $signed(fb));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= START;
    else         q_o <= beats ? data_i : fb;
  end
endmodule

// File: rtl/stream_stats.sv
module stream_stats
  import stream_stats_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o
);
  localparam int N_EXT = 2;

  logic              clr_q;
  logic [DATA_W-1:0] ext_q [N_EXT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= clear_i;
  end

  sum_track #(.W(DATA_W)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_q), .data_i(data_i), .q_o(acc_o)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    localparam fb_kind_e K = (g == 0) ? FB_MAX : FB_MIN;
    extreme_track #(.W(DATA_W), .KIND(K)) u_ext (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_q), .data_i(data_i), .q_o(ext_q[g])
    );
  end

  assign max_o = ext_q[0];
  assign min_o = ext_q[1];
endmodule

// File: rtl/stream_stats_chk.sv
module stream_stats_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [DATA_W-1:0] max_o,
  input logic [DATA_W-1:0] min_o
);
  localparam logic [DATA_W-1:0] MIN_START = {1'b0, {(DATA_W-1){1'b1}}};

  logic       clr_seen;
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_seen <= 1'b0;
      age      <= '0;
    end else begin
      clr_seen <= clear_i;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_values_R1: assert (acc_o == '0 && max_o == '0 && min_o == MIN_START);
    end
  end

  // R2 and R3: start values appear exactly one edge after the capture edge
  assert_start_values_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(clr_seen)) |->
      (acc_o == '0 && max_o == '0 && min_o == MIN_START));

  assert_acc_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && !$past(clr_seen)) |->
      (acc_o == DATA_W'($past(acc_o) + $past(data_i))));

  assert_max_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && !$past(clr_seen)) |->
      ($signed(max_o) >= $signed($past(max_o)) && $signed(max_o) >= $signed($past(data_i))
       && (max_o == $past(max_o) || max_o == $past(data_i))));

  assert_min_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && !$past(clr_seen)) |->
      ($signed(min_o) <= $signed($past(min_o)) && $signed(min_o) <= $signed($past(data_i))
       && (min_o == $past(min_o) || min_o == $past(data_i))));
endmodule

bind stream_stats stream_stats_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .data_i(data_i),
  .acc_o(acc_o), .max_o(max_o), .min_o(min_o)
);

// File: tb/tb_stream_stats.sv
module tb_stream_stats;
  localparam int W = 16;
  localparam logic [W-1:0] MIN_START = 16'h7FFF;
  localparam int N_VEC = 18;
  // {clear, data}
  localparam logic [W:0] VEC [N_VEC] = '{
    {1'b1, 16'h0000}, {1'b0, 16'h1111}, {1'b0, 16'h0005}, {1'b0, 16'hFFFB},
    {1'b0, 16'h7000}, {1'b0, 16'h7000}, {1'b0, 16'h8000}, {1'b0, 16'h7FFF},
    {1'b1, 16'h0003}, {1'b0, 16'h2222}, {1'b0, 16'hFFF0}, {1'b0, 16'h0001},
    {1'b1, 16'h0100}, {1'b1, 16'h0200}, {1'b0, 16'h0300}, {1'b0, 16'h8001},
    {1'b0, 16'hC000}, {1'b0, 16'h4000}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         clear_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] acc_o, max_o, min_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic         m_clr;
  logic [W-1:0] m_acc, m_max, m_min;

  always #4 clk_i = ~clk_i;

  stream_stats #(.DATA_W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .data_i(data_i),
    .acc_o(acc_o), .max_o(max_o), .min_o(min_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at the next negedge
  task automatic step(input logic clr, input logic [W-1:0] d, input string tag);
    clear_i = clr;
    data_i  = d;
    @(posedge clk_i);
    if (m_clr) begin
      m_acc = '0; m_max = '0; m_min = MIN_START;
    end else begin
      m_acc = m_acc + d;
      if ($signed(d) > $signed(m_max)) m_max = d;
      if ($signed(d) < $signed(m_min)) m_min = d;
    end
    m_clr = clr;
    @(negedge clk_i);
    check(tag, "acc", acc_o, m_acc);
    check(tag, "max", max_o, m_max);
    check(tag, "min", min_o, m_min);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1", "acc", acc_o, '0);
    check("R1", "max", max_o, '0);
    check("R1", "min", min_o, MIN_START);
    m_clr = 1'b0; m_acc = '0; m_max = '0; m_min = MIN_START;
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][W], VEC[i][W-1:0], "R4 R5 R6");
    end

    // capture edge samples normally, next edge loads start values and ignores data
    step(1'b1, 16'h0010, "R2");
    step(1'b0, 16'h1234, "R3");
    check("R3", "acc", acc_o, 16'h0000);
    check("R3", "max", max_o, 16'h0000);
    check("R3", "min", min_o, 16'h7FFF);

    step(1'b0, 16'hFFF6, "R7");
    check("R7", "acc", acc_o, 16'hFFF6);
    check("R7", "min", min_o, 16'hFFF6);
    check("R7", "max", max_o, 16'h0000);

    // mid-cycle data change must not reach the outputs
    data_i = 16'h7FFF;
    #2;
    check("R8", "acc", acc_o, 16'hFFF6);
    check("R8", "max", max_o, 16'h0000);
    check("R8", "min", min_o, 16'hFFF6);
    @(negedge clk_i);
    m_acc = m_acc + 16'h7FFF;
    m_max = 16'h7FFF;
    check("R4", "acc", acc_o, m_acc);

    step(1'b1, 16'h0055, "R9");
    step(1'b1, 16'h0066, "R9");
    step(1'b1, 16'h0077, "R9");
    check("R9", "acc", acc_o, 16'h0000);
    check("R9", "min", min_o, 16'h7FFF);
    step(1'b0, 16'h0088, "R9");
    check("R9", "acc", acc_o, 16'h0000);
    step(1'b0, 16'h0099, "R7");
    check("R7", "acc", acc_o, 16'h0099);
    check("R7", "max", max_o, 16'h0099);
    check("R7", "min", min_o, 16'h0099);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule